// File: doc/BRIEF.md
# Exception entry sequencer

This block sits beside a processor core and turns a set of pending exception requests into the start of a handler. Each cycle it is idle, it looks at the request lines, grants exactly one of them by a fixed priority, and works out that exception's vector number. It then writes the supervisor-entry control bits into a new status word and adds four times the vector number to a vector base register to form the table address.

For every exception except reset, it first asks the core to push its context and waits for a "frame saved" acknowledge. Only then does it read the handler address over a simple longword read port that also carries a function code. A reset exception saves nothing. Instead it reads two longwords: the initial supervisor stack pointer at offset 0 and the initial PC at offset 4. When the fetch completes, the new PC and status word, plus the stack pointer after a reset, are presented together for one cycle.

Top module: `exc_seq`

## Requirements
- R1: Request bit positions and their priority, highest first: 0 reset, 1 bus error, 2 address error, 3 trace, 4 interrupt, 5 illegal instruction, 6 privilege violation, 7 TRAP, 8 CHK, 9 divide by zero. When idle with any request set, `grant_o` is one-hot on the highest pending bit in that same cycle; otherwise it is zero.
- R2: Vector numbers are fixed: bus error 2, address error 3, divide by zero 5, CHK 6, privilege 8, trace 9. Illegal is 4 for kind 0 or 3, 10 for kind 1 (line-A) and 11 for kind 2 (line-F). TRAP is 32 + `trap_num_i` when `trapv_i` is 0 and 7 when `trapv_i` is 1.
- R3: For an interrupt, the vector number is taken from `irq_vector_i`, and the new status word's mask field (bits 10:8) is set to `irq_level_i`.
- R4: The handler fetch address is the vector base plus four times the vector number, modulo 2^ADDR_W. The base is zero after `rst_n`, is written by `vbr_we_i`/`vbr_d_i`, and is latched when a request is granted, so writes made during a service do not move that fetch.
- R5: A reset exception makes no save request. It reads offset 0 (which becomes `new_ssp_o`, with `ssp_load_o` high at done) and then offset 4 (which becomes the PC). It clears the vector base to zero and produces status word 16'h2700.
- R6: `bus_fc_o` is 3'b110 during reset fetches and 3'b101 during all other vector fetches.
- R7: For a non-reset exception, the new status word is `sr_i` with bit 13 (supervisor) set, bits 15:14 (trace) cleared, and all other bits kept, except as R3 modifies them.
- R8: For a non-reset exception, `save_req_o` is raised the cycle after the grant and held until `save_ack_i`. No bus request is made before that acknowledge.
- R9: Once raised, `bus_req_o` keeps `bus_addr_o` and `bus_fc_o` stable until a cycle with `bus_ack_i` high, in which `bus_rdata_i` is captured.
- R10: `done_o` is a single-cycle pulse in the cycle after the last bus acknowledge, with `new_pc_o` and `new_sr_o` valid. Requests presented while a service is in progress are not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 10 | Pending exception requests, one bit per source |
| trap_num_i | input | 4 | TRAP operand 0..15 |
| trapv_i | input | 1 | TRAP request is the overflow form |
| illegal_kind_i | input | 2 | 0 plain, 1 line-A, 2 line-F |
| irq_level_i | input | 3 | Level of the interrupt being serviced |
| irq_vector_i | input | 8 | Vector number from the acknowledge unit |
| sr_i | input | 16 | Current status word |
| vbr_we_i | input | 1 | Vector base write strobe |
| vbr_d_i | input | ADDR_W | Vector base write data |
| grant_o | output | 10 | One-hot accepted request |
| save_req_o | output | 1 | Ask core to push context |
| save_ack_i | input | 1 | Context push finished |
| bus_req_o | output | 1 | Longword read request |
| bus_addr_o | output | ADDR_W | Read address |
| bus_fc_o | output | 3 | Function code of the read |
| bus_ack_i | input | 1 | Read completes, data valid |
| bus_rdata_i | input | DATA_W | Read data |
| done_o | output | 1 | New PC/SR valid this cycle |
| new_pc_o | output | DATA_W | Handler address |
| new_sr_o | output | 16 | Status word for the handler |
| ssp_load_o | output | 1 | Load new stack pointer (reset only) |
| new_ssp_o | output | DATA_W | Initial supervisor stack pointer |

## Verification
The bench checks the priority order with mixed request sets in which the winner is next to a weaker neighbour, because a swapped bit order would grant the wrong source and fetch from the wrong slot. It also covers a vector base near the top of the address space, where a truncated adder would wrap incorrectly. It checks that the handler fetch never starts before the frame-saved acknowledge, and that a reset fetches offsets 0 then 4 under the program function code with no save request, since a sequencer that reused the normal path would save context or read only once. Finally it writes the base register and raises new requests in the middle of a service: a design that did not latch its address would fetch from the new base, and one that granted while busy would pulse `grant_o`.

// File: rtl/exc_seq_pkg.sv
// Package: shared constants, types and vector-number lookup for the
// exception entry sequencer. Assumes a 10-source request vector whose
// bit index is also the priority rank (0 is highest).
package exc_seq_pkg;

    localparam int NUM_SRC = 10;
    localparam int SRC_W   = $clog2(NUM_SRC);
    localparam int SR_W    = 16;

    // Request bit positions, in priority order
    localparam logic [SRC_W-1:0] SRC_RESET   = SRC_W'(0);
    localparam logic [SRC_W-1:0] SRC_BUSERR  = SRC_W'(1);
    localparam logic [SRC_W-1:0] SRC_ADRERR  = SRC_W'(2);
    localparam logic [SRC_W-1:0] SRC_TRACE   = SRC_W'(3);
    localparam logic [SRC_W-1:0] SRC_IRQ     = SRC_W'(4);
    localparam logic [SRC_W-1:0] SRC_ILLEGAL = SRC_W'(5);
    localparam logic [SRC_W-1:0] SRC_PRIV    = SRC_W'(6);
    localparam logic [SRC_W-1:0] SRC_TRAP    = SRC_W'(7);
    localparam logic [SRC_W-1:0] SRC_CHK     = SRC_W'(8);
    localparam logic [SRC_W-1:0] SRC_DIVZ    = SRC_W'(9);

    // Illegal-opcode flavours
    localparam logic [1:0] ILL_LINE_A = 2'd1;
    localparam logic [1:0] ILL_LINE_F = 2'd2;

    // Function codes for vector reads
    localparam logic [2:0] FC_SUP_PROG = 3'b110;
    localparam logic [2:0] FC_SUP_DATA = 3'b101;

    // Status word fields
    localparam int SR_TRACE_HI = 15;
    localparam int SR_TRACE_LO = 14;
    localparam int SR_SUPER    = 13;
    localparam int SR_MASK_HI  = 10;
    localparam int SR_MASK_LO  = 8;
    localparam logic [SR_W-1:0] SR_AFTER_RESET = 16'h2700;

    localparam logic [7:0] TRAP_BASE_VEC = 8'd32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE,
        ST_FETCH_SP,
        ST_FETCH_PC,
        ST_DONE
    } seq_state_e;

    // Map a granted source to its vector number
    function automatic logic [7:0] vector_of(
        input logic [SRC_W-1:0] src,
        input logic [3:0]       trap_num,
        input logic             trapv,
        input logic [1:0]       ill_kind,
        input logic [7:0]       irq_vec
    );
        logic [7:0] v;
        case (src)
            SRC_RESET:   v = 8'd0;
            SRC_BUSERR:  v = 8'd2;
            SRC_ADRERR:  v = 8'd3;
            SRC_TRACE:   v = 8'd9;
            SRC_IRQ:     v = irq_vec;
            SRC_ILLEGAL: v = (ill_kind == ILL_LINE_A) ? 8'd10 :
                             (ill_kind == ILL_LINE_F) ? 8'd11 : 8'd4;
            SRC_PRIV:    v = 8'd8;
            SRC_TRAP:    v = trapv ? 8'd7 : (TRAP_BASE_VEC + {4'd0, trap_num});
            SRC_CHK:     v = 8'd6;
            SRC_DIVZ:    v = 8'd5;
            default:     v = 8'd4;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/exc_prio_pick.sv
// Module: fixed-priority picker. Bit 0 of req wins over every higher bit.
// Assumes requests are levels sampled by the caller; purely combinational.
module exc_prio_pick #(
    parameter int N     = 10,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    // Prefix-OR chain: a bit is granted when no lower bit is pending
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]  = req[i] & ~seen[i];
        assign seen[i+1] = seen[i] | req[i];
    end

    assign any = seen[N];

    // Encode the granted bit as an index
    always_comb begin
        idx = '0;
        for (int k = 0; k < N; k++) begin
            if (grant[k]) idx = IDX_W'(k);
        end
    end

    p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (any == (req != '0)));

    p_grant_lowest_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req[0]) |-> grant[0]);

endmodule

// File: rtl/exc_vec_calc.sv
// Module: for the granted source, forms the vector number, the table
// address (base + 4*vector) and the status word for the handler.
// Assumes the base register is forced to zero for a reset exception.
module exc_vec_calc
    import exc_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [SRC_W-1:0]  src,
    input  logic [3:0]        trap_num,
    input  logic              trapv,
    input  logic [1:0]        ill_kind,
    input  logic [2:0]        irq_level,
    input  logic [7:0]        irq_vec,
    input  logic [SR_W-1:0]   sr_cur,
    input  logic [ADDR_W-1:0] vbr,
    output logic [7:0]        vec_num,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [SR_W-1:0]   sr_next
);
    localparam int OFS_W = 10;

    logic [ADDR_W-1:0] base;
    logic [OFS_W-1:0]  offset;

    // Vector number lookup
    assign vec_num = vector_of(src, trap_num, trapv, ill_kind, irq_vec);

    // Table address: reset always reads from address zero
    assign base     = (src == SRC_RESET) ? '0 : vbr;
    assign offset   = {vec_num, 2'b00};
    assign vec_addr = base + ADDR_W'(offset);

    // Supervisor entry: set S, clear both trace bits, adjust mask
    always_comb begin
        sr_next = sr_cur;
        sr_next[SR_TRACE_HI:SR_TRACE_LO] = 2'b00;
        sr_next[SR_SUPER] = 1'b1;
        if (src == SRC_IRQ) sr_next[SR_MASK_HI:SR_MASK_LO] = irq_level;
        if (src == SRC_RESET) sr_next = SR_AFTER_RESET;
    end

endmodule

// File: rtl/exc_fetch_ctrl.sv
// Module: sequencing state machine. Waits for the context save (non-reset),
// runs one or two longword reads, then pulses done with the results.
// Assumes start is only raised while busy is low.
module exc_fetch_ctrl
    import exc_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_reset,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [SR_W-1:0]   start_sr,
    output logic              busy,
    output logic              save_req,
    input  logic              save_ack,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [2:0]        bus_fc,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              done,
    output logic [DATA_W-1:0] new_pc,
    output logic [SR_W-1:0]   new_sr,
    output logic              ssp_load,
    output logic [DATA_W-1:0] new_ssp
);
    localparam logic [ADDR_W-1:0] LONG_STEP = ADDR_W'(4);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SR_W-1:0]   sr_q;
    logic [DATA_W-1:0] pc_q;
    logic [DATA_W-1:0] ssp_q;
    logic              is_reset_q;

    // State transitions and capture of request parameters and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            sr_q       <= '0;
            pc_q       <= '0;
            ssp_q      <= '0;
            is_reset_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        addr_q     <= start_addr;
                        sr_q       <= start_sr;
                        is_reset_q <= start_reset;
                        state_q    <= start_reset ? ST_FETCH_SP : ST_SAVE;
                    end
                end
                ST_SAVE: begin
                    if (save_ack) state_q <= ST_FETCH_PC;
                end
                ST_FETCH_SP: begin
                    if (bus_ack) begin
                        ssp_q   <= bus_rdata;
                        addr_q  <= addr_q + LONG_STEP;
                        state_q <= ST_FETCH_PC;
                    end
                end
                ST_FETCH_PC: begin
                    if (bus_ack) begin
                        pc_q    <= bus_rdata;
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the current state
    always_comb begin
        busy     = (state_q != ST_IDLE);
        save_req = (state_q == ST_SAVE);
        bus_req  = (state_q == ST_FETCH_SP) || (state_q == ST_FETCH_PC);
        bus_addr = addr_q;
        bus_fc   = is_reset_q ? FC_SUP_PROG : FC_SUP_DATA;
        done     = (state_q == ST_DONE);
        ssp_load = (state_q == ST_DONE) && is_reset_q;
        new_pc   = pc_q;
        new_sr   = sr_q;
        new_ssp  = ssp_q;
    end

    p_fetch_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !save_ack) |=> !bus_req);

    p_bus_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_fc)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_reset_nosave_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_fc == FC_SUP_PROG) |-> !save_req);

    p_done_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bus_ack));

endmodule

// File: rtl/exc_seq.sv
// Module: top of the exception entry sequencer. Holds the vector base
// register, arbitrates requests while idle, and hands the chosen entry to
// the fetch controller. Assumes requests are held by their sources until
// granted.
module exc_seq
    import exc_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [3:0]         trap_num_i,
    input  logic               trapv_i,
    input  logic [1:0]         illegal_kind_i,
    input  logic [2:0]         irq_level_i,
    input  logic [7:0]         irq_vector_i,
    input  logic [SR_W-1:0]    sr_i,
    input  logic               vbr_we_i,
    input  logic [ADDR_W-1:0]  vbr_d_i,
    output logic [NUM_SRC-1:0] grant_o,
    output logic               save_req_o,
    input  logic               save_ack_i,
    output logic               bus_req_o,
    output logic [ADDR_W-1:0]  bus_addr_o,
    output logic [2:0]         bus_fc_o,
    input  logic               bus_ack_i,
    input  logic [DATA_W-1:0]  bus_rdata_i,
    output logic               done_o,
    output logic [DATA_W-1:0]  new_pc_o,
    output logic [SR_W-1:0]    new_sr_o,
    output logic               ssp_load_o,
    output logic [DATA_W-1:0]  new_ssp_o
);
    logic [NUM_SRC-1:0] pick_grant;
    logic               pick_any;
    logic [SRC_W-1:0]   pick_idx;
    logic [ADDR_W-1:0]  vbr_q;
    logic [7:0]         vec_num;
    logic [ADDR_W-1:0]  vec_addr;
    logic [SR_W-1:0]    sr_next;
    logic               busy;
    logic               accept;
    logic               accept_reset;

    exc_prio_pick #(.N(NUM_SRC)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_i),
        .grant (pick_grant),
        .any   (pick_any),
        .idx   (pick_idx)
    );

    exc_vec_calc #(.ADDR_W(ADDR_W)) u_calc (
        .src       (pick_idx),
        .trap_num  (trap_num_i),
        .trapv     (trapv_i),
        .ill_kind  (illegal_kind_i),
        .irq_level (irq_level_i),
        .irq_vec   (irq_vector_i),
        .sr_cur    (sr_i),
        .vbr       (vbr_q),
        .vec_num   (vec_num),
        .vec_addr  (vec_addr),
        .sr_next   (sr_next)
    );

    // Accept only while the sequencer is idle
    assign accept       = pick_any && !busy;
    assign accept_reset = accept && (pick_idx == SRC_RESET);
    assign grant_o      = accept ? pick_grant : '0;

    // Vector base register: cleared by block reset and by a reset exception
    always_ff @(posedge clk) begin
        if (!rst_n)            vbr_q <= '0;
        else if (accept_reset) vbr_q <= '0;
        else if (vbr_we_i)     vbr_q <= vbr_d_i;
    end

    exc_fetch_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .start_reset (accept_reset),
        .start_addr  (vec_addr),
        .start_sr    (sr_next),
        .busy        (busy),
        .save_req    (save_req_o),
        .save_ack    (save_ack_i),
        .bus_req     (bus_req_o),
        .bus_addr    (bus_addr_o),
        .bus_fc      (bus_fc_o),
        .bus_ack     (bus_ack_i),
        .bus_rdata   (bus_rdata_i),
        .done        (done_o),
        .new_pc      (new_pc_o),
        .new_sr      (new_sr_o),
        .ssp_load    (ssp_load_o),
        .new_ssp     (new_ssp_o)
    );

    p_sr_super_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (new_sr_o[SR_SUPER] && new_sr_o[SR_TRACE_HI:SR_TRACE_LO] == 2'b00));

    p_no_grant_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req_o || bus_req_o || done_o) |-> (grant_o == '0));

    p_reset_fc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o[0] |=> (bus_req_o && bus_fc_o == FC_SUP_PROG && bus_addr_o == '0));

    p_vbr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o[0] |=> (vbr_q == '0));

endmodule

// File: tb/exc_seq_tb_top.sv
module exc_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;

    typedef struct packed {
        logic [9:0]  req;
        logic [3:0]  trapn;
        logic        tv;
        logic [1:0]  ill;
        logic [2:0]  lvl;
        logic [7:0]  ivec;
        logic [31:0] vbr;
        logic [15:0] sr;
        logic [9:0]  egrant;
        logic [31:0] eaddr;
        logic [15:0] esr;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{10'h022, 4'd0, 1'b0, 2'd0, 3'd0, 8'h00, 32'h0000_0000, 16'h0000, 10'h002, 32'h0000_0008, 16'h2000},
        '{10'h218, 4'd0, 1'b0, 2'd0, 3'd3, 8'h50, 32'h0000_1000, 16'h8005, 10'h008, 32'h0000_1024, 16'h2005},
        '{10'h010, 4'd0, 1'b0, 2'd0, 3'd5, 8'h40, 32'h0000_2000, 16'h0300, 10'h010, 32'h0000_2100, 16'h2500},
        '{10'h020, 4'd0, 1'b0, 2'd0, 3'd0, 8'h00, 32'h0000_0000, 16'hC01F, 10'h020, 32'h0000_0010, 16'h201F},
        '{10'h020, 4'd0, 1'b0, 2'd1, 3'd0, 8'h00, 32'h0000_0000, 16'h0000, 10'h020, 32'h0000_0028, 16'h2000},
        '{10'h020, 4'd0, 1'b0, 2'd2, 3'd0, 8'h00, 32'h0000_0000, 16'h0000, 10'h020, 32'h0000_002C, 16'h2000},
        '{10'h0C0, 4'd0, 1'b0, 2'd0, 3'd0, 8'h00, 32'h0000_0000, 16'h0000, 10'h040, 32'h0000_0020, 16'h2000},
        '{10'h080, 4'd15,1'b0, 2'd0, 3'd0, 8'h00, 32'h0000_0100, 16'h0704, 10'h080, 32'h0000_01BC, 16'h2704},
        '{10'h080, 4'd3, 1'b1, 2'd0, 3'd0, 8'h00, 32'h0000_0000, 16'h0000, 10'h080, 32'h0000_001C, 16'h2000},
        '{10'h300, 4'd0, 1'b0, 2'd0, 3'd0, 8'h00, 32'h0000_0000, 16'h0000, 10'h100, 32'h0000_0018, 16'h2000},
        '{10'h200, 4'd0, 1'b0, 2'd0, 3'd0, 8'h00, 32'h0000_0000, 16'h0000, 10'h200, 32'h0000_0014, 16'h2000},
        '{10'h00C, 4'd0, 1'b0, 2'd0, 3'd0, 8'h00, 32'h0000_0000, 16'h0000, 10'h004, 32'h0000_000C, 16'h2000},
        '{10'h010, 4'd0, 1'b0, 2'd0, 3'd7, 8'hFF, 32'hFFFF_FC00, 16'h2000, 10'h010, 32'hFFFF_FFFC, 16'h2700},
        '{10'h070, 4'd0, 1'b0, 2'd0, 3'd2, 8'h19, 32'h0000_0000, 16'h2000, 10'h010, 32'h0000_0064, 16'h2200}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [9:0]    req = '0;
    logic [3:0]    trapn = '0;
    logic          tv = 1'b0;
    logic [1:0]    ill = '0;
    logic [2:0]    lvl = '0;
    logic [7:0]    ivec = '0;
    logic [15:0]   sr = '0;
    logic          vbr_we = 1'b0;
    logic [AW-1:0] vbr_d = '0;
    logic [9:0]    grant;
    logic          save_req;
    logic          save_ack = 1'b0;
    logic          bus_req;
    logic [AW-1:0] bus_addr;
    logic [2:0]    bus_fc;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          done;
    logic [DW-1:0] new_pc;
    logic [15:0]   new_sr;
    logic          ssp_load;
    logic [DW-1:0] new_ssp;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    exc_seq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .trap_num_i(trapn), .trapv_i(tv),
        .illegal_kind_i(ill), .irq_level_i(lvl), .irq_vector_i(ivec), .sr_i(sr),
        .vbr_we_i(vbr_we), .vbr_d_i(vbr_d), .grant_o(grant), .save_req_o(save_req),
        .save_ack_i(save_ack), .bus_req_o(bus_req), .bus_addr_o(bus_addr),
        .bus_fc_o(bus_fc), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
        .done_o(done), .new_pc_o(new_pc), .new_sr_o(new_sr),
        .ssp_load_o(ssp_load), .new_ssp_o(new_ssp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Serve one non-reset exception and check every phase
    task automatic serve(input vec_t v, input bit wr_vbr, input logic [31:0] pc);
        if (wr_vbr) begin
            @(negedge clk); vbr_we = 1'b1; vbr_d = v.vbr;
            @(negedge clk); vbr_we = 1'b0;
        end
        @(negedge clk);
        trapn = v.trapn; tv = v.tv; ill = v.ill; lvl = v.lvl; ivec = v.ivec; sr = v.sr;
        req = v.req;
        #1;
        chk(grant == v.egrant, "R1 grant", 32'(grant), 32'(v.egrant));
        @(negedge clk); req = '0;
        chk(save_req == 1'b1, "R8 save_req raised", 32'(save_req), 32'd1);
        chk(bus_req == 1'b0, "R8 no fetch before ack", 32'(bus_req), 32'd0);
        @(negedge clk);
        chk(bus_req == 1'b0, "R8 still held off", 32'(bus_req), 32'd0);
        save_ack = 1'b1;
        @(negedge clk); save_ack = 1'b0;
        chk(bus_req == 1'b1, "R8 fetch after ack", 32'(bus_req), 32'd1);
        chk(bus_addr == v.eaddr, "R2 R4 fetch address", bus_addr, v.eaddr);
        chk(bus_fc == 3'b101, "R6 data fc", 32'(bus_fc), 32'h5);
        @(negedge clk);
        chk(bus_req && bus_addr == v.eaddr, "R9 held without ack", bus_addr, v.eaddr);
        bus_ack = 1'b1; bus_rdata = pc;
        @(negedge clk); bus_ack = 1'b0;
        chk(done == 1'b1, "R10 done", 32'(done), 32'd1);
        chk(new_pc == pc, "R10 new pc", new_pc, pc);
        chk(new_sr == v.esr, "R7 R3 new sr", 32'(new_sr), 32'(v.esr));
        chk(ssp_load == 1'b0, "R5 no ssp load", 32'(ssp_load), 32'd0);
        @(negedge clk);
        chk(done == 1'b0, "R10 done one cycle", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        vec_t be;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        chk(save_req == 0 && bus_req == 0, "R8 R9 idle after reset", 32'({save_req, bus_req}), 32'd0);
        chk(done == 0, "R10 no done after reset", 32'(done), 32'd0);
        chk(grant == 0, "R1 no grant without request", 32'(grant), 32'd0);
        // Base register is zero after reset: bus error fetches address 8
        be = TBL[0];
        serve(be, 1'b0, 32'h0000_1000);

        // Table walk
        for (int i = 0; i < NV; i++) serve(TBL[i], 1'b1, 32'h0001_0000 + 32'(i * 16));

        // Reset exception with every request pending and a nonzero base
        @(negedge clk); vbr_we = 1'b1; vbr_d = 32'h0000_5000;
        @(negedge clk); vbr_we = 1'b0; sr = 16'h8000; req = 10'h3FF;
        #1;
        chk(grant == 10'h001, "R1 reset wins", 32'(grant), 32'h1);
        @(negedge clk); req = '0;
        chk(save_req == 0, "R5 reset no save", 32'(save_req), 32'd0);
        chk(bus_req && bus_addr == 32'h0, "R5 first read offset 0", bus_addr, 32'h0);
        chk(bus_fc == 3'b110, "R6 reset fc first", 32'(bus_fc), 32'h6);
        bus_ack = 1'b1; bus_rdata = 32'h00FF_0000;
        @(negedge clk); bus_ack = 1'b0;
        chk(bus_req && bus_addr == 32'h4, "R5 second read offset 4", bus_addr, 32'h4);
        chk(bus_fc == 3'b110, "R6 reset fc second", 32'(bus_fc), 32'h6);
        bus_ack = 1'b1; bus_rdata = 32'h0000_0400;
        @(negedge clk); bus_ack = 1'b0;
        chk(done && ssp_load, "R5 done with ssp load", 32'({done, ssp_load}), 32'h3);
        chk(new_ssp == 32'h00FF_0000, "R5 new ssp", new_ssp, 32'h00FF_0000);
        chk(new_pc == 32'h0000_0400, "R5 new pc", new_pc, 32'h400);
        chk(new_sr == 16'h2700, "R5 reset sr", 32'(new_sr), 32'h2700);
        // Base cleared by reset exception: bus error fetches address 8 again
        serve(be, 1'b0, 32'h0000_2000);

        // Base write and new request during a service
        @(negedge clk); vbr_we = 1'b1; vbr_d = 32'h0000_3000;
        @(negedge clk); vbr_we = 1'b0; req = 10'h200;
        @(negedge clk); req = 10'h002; vbr_we = 1'b1; vbr_d = 32'h0000_7000;
        #1;
        chk(grant == 10'h000, "R10 no grant while busy", 32'(grant), 32'h0);
        @(negedge clk); req = '0; vbr_we = 1'b0; save_ack = 1'b1;
        @(negedge clk); save_ack = 1'b0;
        chk(bus_addr == 32'h0000_3014, "R4 address latched at grant", bus_addr, 32'h3014);
        bus_ack = 1'b1; bus_rdata = 32'hABCD_0000;
        @(negedge clk); bus_ack = 1'b0;
        chk(done == 1'b1, "R10 done after busy test", 32'(done), 32'd1);
        @(negedge clk);
        chk(save_req == 0 && bus_req == 0, "R10 dropped request not served", 32'({save_req, bus_req}), 32'd0);
        // New base now in effect: divide by zero at 0x7014
        be = TBL[10]; be.eaddr = 32'h0000_7014;
        serve(be, 1'b0, 32'h0000_3000);

        summary();
    end
endmodule